// File: doc/BRIEF.md
# Dual-Master Extended Address Register

This block drives the top byte of a 24-bit system address bus on a board that carries two bus masters which take turns: a narrow master with a 16-bit address and a wide master with a 20-bit address. Software selects the extended address by writing one byte to a decoded I/O output port. The block holds that byte and presents it as address bits 23..16.

When the narrow master owns the bus, all eight held bits go out. When the wide master owns the bus, it supplies bits 19..16 itself, and only the upper nibble of the held byte is used for bits 23..20. The byte is not changed by this, so the narrow master finds its full value again when it returns. The output register loads only on the one-clock address-latch-enable pulse, so a new value first shows at the start of the following bus cycle.

The output enable drops during power-on clear and bus reset. It also drops while a DMA device asks for the address lines, unless an option bit tells the block to ignore that request. The comparator that decodes the port address is outside this block.

Top module: `xaddr_hi_drive`

## Requirements
- R1: A qualified port write loads the held byte on the first clock edge at which the qualifier has gone from 1 to 0. The byte loaded is `data_i` as sampled in the last clock cycle of the qualifier.
- R2: The write qualifier is `port_hit_i & out_cycle_i & wr_act_i`. If any one of the three is 0, the held byte is not changed.
- R3: On an address-latch-enable clock with `wide_master_i` = 0 (narrow master), `ext_addr_o[7:0]` takes the full held byte.
- R4: On an address-latch-enable clock with `wide_master_i` = 1 (wide master), `ext_addr_o[7:4]` takes held bits 7..4 and `ext_addr_o[3:0]` takes `wide_nib_i[3:0]`.
- R5: Running with the wide master never alters the held byte. A later narrow-master latch shows all eight bits as they were written.
- R6: `ext_addr_o` changes only on the clock edge at which `ale_i` is 1. A write with no following `ale_i` leaves the output unchanged.
- R7: Synchronous `rst` (power-on clear) sets the held byte and `ext_addr_o` to 0, and sets `ext_addr_oe_o` to 0.
- R8: `bus_reset_i` clears the held byte to 0 only when `opt_clr_on_reset_i` = 1. When that bit is 0, the held byte survives.
- R9: `ext_addr_oe_o` is a register. One clock after `bus_reset_i` = 1 it is 0. One clock after `dma_addr_off_i` = 1 with `opt_ignore_dma_i` = 0 it is 0. Otherwise it is 1 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| bus_reset_i | input | 1 | Bus reset, active high |
| dma_addr_off_i | input | 1 | DMA request to release the address lines |
| opt_clr_on_reset_i | input | 1 | 1: bus reset clears the held byte |
| opt_ignore_dma_i | input | 1 | 1: the DMA release request does not affect the enable |
| port_hit_i | input | 1 | Port address comparator match |
| out_cycle_i | input | 1 | Bus status shows an output cycle |
| wr_act_i | input | 1 | Write strobe active (high) |
| data_i | input | 8 | Data bus |
| ale_i | input | 1 | One-clock address-latch-enable pulse |
| wide_master_i | input | 1 | 1: wide (20-bit) master owns the bus |
| wide_nib_i | input | 4 | Wide master's address bits 19..16 |
| ext_addr_o | output | 8 | Address bits 23..16 |
| ext_addr_oe_o | output | 1 | Output enable for `ext_addr_o` |

## Verification
The bound checker checks on every cycle that the output holds still without a latch pulse, that a latch pulse copies the full byte or the split nibble/byte value according to the active master, that the held byte changes only at the end of a qualified write or on an enabled bus-reset clear, and that the enable follows the reset and DMA conditions one clock later. Only the bench scenarios can show the following: the captured value is the data of the strobe's last cycle and not the data after the strobe; each missing qualifier term blocks the write; the full byte comes back after a run on the wide master; and the state after power-on clear.

// File: rtl/xah_pkg.sv
package xah_pkg;
  typedef enum logic {
    MST_NARROW = 1'b0,
    MST_WIDE   = 1'b1
  } master_e;
endpackage

// File: rtl/xah_port_capture.sv
// Holds the byte written to the extended-address port.
// The write completes when the qualifier ends; bus-reset clear has priority.
module xah_port_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_reset_i,
  input  logic         opt_clr_on_reset_i,
  input  logic         port_hit_i,
  input  logic         out_cycle_i,
  input  logic         wr_act_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] held_o
);
  logic         qual;
  logic         qual_d;
  logic [W-1:0] data_hold;
  logic         wr_done;
  logic         clr_req;

  assign qual    = port_hit_i & out_cycle_i & wr_act_i;
  assign wr_done = qual_d & ~qual;
  assign clr_req = bus_reset_i & opt_clr_on_reset_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_d    <= 1'b0;
      data_hold <= '0;
      held_o    <= '0;
    end else begin
      qual_d <= qual;
      if (qual) data_hold <= data_i;
      if (clr_req)      held_o <= '0;
      else if (wr_done) held_o <= data_hold;
    end
  end
endmodule

// File: rtl/xah_nib_select.sv
// Per-bit choice between the held byte and the wide master's own lines.
module xah_nib_select #(
  parameter int W     = 8,
  parameter int OWN_W = 4
) (
  input  xah_pkg::master_e mst_i,
  input  logic [W-1:0]     held_i,
  input  logic [OWN_W-1:0] own_i,
  output logic [W-1:0]     sel_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < OWN_W) begin : g_own
      assign sel_o[i] = (mst_i == xah_pkg::MST_WIDE) ? own_i[i] : held_i[i];
    end else begin : g_held
      assign sel_o[i] = held_i[i];
    end
  end
endmodule

// File: rtl/xah_out_stage.sv
// Registered output byte (reloads on the latch pulse) and registered enable.
module xah_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ale_i,
  input  logic [W-1:0] sel_i,
  input  logic         bus_reset_i,
  input  logic         dma_addr_off_i,
  input  logic         opt_ignore_dma_i,
  output logic [W-1:0] addr_o,
  output logic         oe_o
);
  logic drop;
  assign drop = bus_reset_i | (dma_addr_off_i & ~opt_ignore_dma_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      oe_o   <= 1'b0;
    end else begin
      if (ale_i) addr_o <= sel_i;
      oe_o <= ~drop;
    end
  end
endmodule

// File: rtl/xaddr_hi_drive.sv
module xaddr_hi_drive #(
  parameter int HI_W  = 8,
  parameter int OWN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_reset_i,
  input  logic             dma_addr_off_i,
  input  logic             opt_clr_on_reset_i,
  input  logic             opt_ignore_dma_i,
  input  logic             port_hit_i,
  input  logic             out_cycle_i,
  input  logic             wr_act_i,
  input  logic [HI_W-1:0]  data_i,
  input  logic             ale_i,
  input  logic             wide_master_i,
  input  logic [OWN_W-1:0] wide_nib_i,
  output logic [HI_W-1:0]  ext_addr_o,
  output logic             ext_addr_oe_o
);
  xah_pkg::master_e mst;
  logic [HI_W-1:0]  held_byte;
  logic [HI_W-1:0]  sel_byte;

  assign mst = xah_pkg::master_e'(wide_master_i);

  xah_port_capture #(.W(HI_W)) u_cap (
    .clk                (clk),
    .rst                (rst),
    .bus_reset_i        (bus_reset_i),
    .opt_clr_on_reset_i (opt_clr_on_reset_i),
    .port_hit_i         (port_hit_i),
    .out_cycle_i        (out_cycle_i),
    .wr_act_i           (wr_act_i),
    .data_i             (data_i),
    .held_o             (held_byte)
  );

  xah_nib_select #(.W(HI_W), .OWN_W(OWN_W)) u_sel (
    .mst_i  (mst),
    .held_i (held_byte),
    .own_i  (wide_nib_i),
    .sel_o  (sel_byte)
  );

  xah_out_stage #(.W(HI_W)) u_out (
    .clk              (clk),
    .rst              (rst),
    .ale_i            (ale_i),
    .sel_i            (sel_byte),
    .bus_reset_i      (bus_reset_i),
    .dma_addr_off_i   (dma_addr_off_i),
    .opt_ignore_dma_i (opt_ignore_dma_i),
    .addr_o           (ext_addr_o),
    .oe_o             (ext_addr_oe_o)
  );
endmodule

// File: rtl/xah_checker.sv
module xah_checker #(
  parameter int HI_W  = 8,
  parameter int OWN_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_reset_i,
  input logic             dma_addr_off_i,
  input logic             opt_clr_on_reset_i,
  input logic             opt_ignore_dma_i,
  input logic             port_hit_i,
  input logic             out_cycle_i,
  input logic             wr_act_i,
  input logic             ale_i,
  input logic             wide_master_i,
  input logic [OWN_W-1:0] wide_nib_i,
  input logic [HI_W-1:0]  held_byte,
  input logic [HI_W-1:0]  ext_addr_o,
  input logic             ext_addr_oe_o
);
  logic seen_q;
  logic wr_end;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= port_hit_i & out_cycle_i & wr_act_i;
  end
  assign wr_end = seen_q & ~(port_hit_i & out_cycle_i & wr_act_i);

  // R3
  a_r3_narrow_full: assert property (@(posedge clk) disable iff (rst)
    (ale_i && !wide_master_i) |=> ext_addr_o == $past(held_byte));
  // R4
  a_r4_wide_split: assert property (@(posedge clk) disable iff (rst)
    (ale_i && wide_master_i) |=>
      (ext_addr_o[HI_W-1:OWN_W] == $past(held_byte[HI_W-1:OWN_W]) &&
       ext_addr_o[OWN_W-1:0] == $past(wide_nib_i)));
  // R6
  a_r6_hold_without_ale: assert property (@(posedge clk) disable iff (rst)
    !ale_i |=> $stable(ext_addr_o));
  // R1, R2, R5
  a_r5_byte_only_on_write: assert property (@(posedge clk) disable iff (rst)
    (!wr_end && !(bus_reset_i && opt_clr_on_reset_i)) |=> $stable(held_byte));
  // R8
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_i && opt_clr_on_reset_i) |=> held_byte == '0);
  // R9
  a_r9_oe_drop: assert property (@(posedge clk) disable iff (rst)
    (bus_reset_i || (dma_addr_off_i && !opt_ignore_dma_i)) |=> !ext_addr_oe_o);
  a_r9_oe_rise: assert property (@(posedge clk) disable iff (rst)
    (!bus_reset_i && !(dma_addr_off_i && !opt_ignore_dma_i)) |=> ext_addr_oe_o);
endmodule

bind xaddr_hi_drive xah_checker #(.HI_W(HI_W), .OWN_W(OWN_W)) u_chk (
  .clk                (clk),
  .rst                (rst),
  .bus_reset_i        (bus_reset_i),
  .dma_addr_off_i     (dma_addr_off_i),
  .opt_clr_on_reset_i (opt_clr_on_reset_i),
  .opt_ignore_dma_i   (opt_ignore_dma_i),
  .port_hit_i         (port_hit_i),
  .out_cycle_i        (out_cycle_i),
  .wr_act_i           (wr_act_i),
  .ale_i              (ale_i),
  .wide_master_i      (wide_master_i),
  .wide_nib_i         (wide_nib_i),
  .held_byte          (held_byte),
  .ext_addr_o         (ext_addr_o),
  .ext_addr_oe_o      (ext_addr_oe_o)
);

// File: tb/xaddr_hi_drive_test.sv
`timescale 1ns/1ps
module xaddr_hi_drive_test;
  logic       clk = 1'b0;
  logic       rst, bus_reset, dma_off, opt_clr, opt_ign;
  logic       hit, outc, wr, ale, wide;
  logic [7:0] data;
  logic [3:0] nib;
  logic [7:0] ext;
  logic       oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  xaddr_hi_drive uut (
    .clk(clk), .rst(rst), .bus_reset_i(bus_reset), .dma_addr_off_i(dma_off),
    .opt_clr_on_reset_i(opt_clr), .opt_ignore_dma_i(opt_ign),
    .port_hit_i(hit), .out_cycle_i(outc), .wr_act_i(wr), .data_i(data),
    .ale_i(ale), .wide_master_i(wide), .wide_nib_i(nib),
    .ext_addr_o(ext), .ext_addr_oe_o(oe)
  );

  // {do_write, data, wide, nib, expected ext}
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 8'hA5, 1'b0, 4'h0, 8'hA5},
    {1'b0, 8'h00, 1'b1, 4'h3, 8'hA3},
    {1'b1, 8'h3C, 1'b1, 4'hF, 8'h3F},
    {1'b0, 8'h00, 1'b0, 4'h9, 8'h3C},
    {1'b1, 8'h00, 1'b0, 4'h0, 8'h00},
    {1'b1, 8'hFF, 1'b1, 4'h0, 8'hF0},
    {1'b0, 8'h00, 1'b0, 4'h0, 8'hFF},
    {1'b1, 8'h81, 1'b1, 4'h6, 8'h86}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // two-cycle qualified write; data changes after the strobe ends
  task automatic port_write(input logic [7:0] d, input logic h, input logic o, input logic w);
    @(negedge clk); hit = h; outc = o; wr = w; data = d;
    @(negedge clk); data = d;
    @(negedge clk); hit = 0; outc = 0; wr = 0; data = ~d;
    @(negedge clk);
  endtask

  // latch pulse; returns at the negedge after the loading edge
  task automatic latch(input logic w, input logic [3:0] n);
    @(negedge clk); ale = 1; wide = w; nib = n;
    @(negedge clk); ale = 0;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; bus_reset = 0; dma_off = 0; opt_clr = 0; opt_ign = 0;
    hit = 0; outc = 0; wr = 0; ale = 0; wide = 0; nib = 0; data = 0;
    repeat (3) @(negedge clk);
    check("R7 reset addr", ext, 8'h00);
    check("R7 reset oe", {7'd0, oe}, 8'h00);
    rst = 0;
    @(negedge clk);
    check("R9 oe after reset", {7'd0, oe}, 8'h01);

    // vector table: R1 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) port_write(VEC[i][20:13], 1, 1, 1);
      latch(VEC[i][12], VEC[i][11:8]);
      check($sformatf("R1/R3/R4/R5 vec%0d", i), ext, VEC[i][7:0]);
    end

    // R6: write without ALE leaves output; then ALE shows it
    latch(0, 0);
    check("R6 base", ext, 8'h81);
    port_write(8'h5E, 1, 1, 1);
    repeat (3) @(negedge clk);
    check("R6 no ale", ext, 8'h81);
    latch(0, 0);
    check("R6 after ale", ext, 8'h5E);

    // R2: each missing qualifier term blocks the write
    port_write(8'h11, 0, 1, 1);
    port_write(8'h22, 1, 0, 1);
    port_write(8'h33, 1, 1, 0);
    latch(0, 0);
    check("R2 blocked writes", ext, 8'h5E);

    // R8 / R9: bus reset without clear option
    opt_clr = 0;
    @(negedge clk); bus_reset = 1;
    @(negedge clk);
    check("R9 oe in bus reset", {7'd0, oe}, 8'h00);
    bus_reset = 0;
    @(negedge clk);
    check("R9 oe after bus reset", {7'd0, oe}, 8'h01);
    latch(0, 0);
    check("R8 kept without option", ext, 8'h5E);

    // R8: bus reset with clear option
    opt_clr = 1;
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
    latch(0, 0);
    check("R8 cleared with option", ext, 8'h00);
    opt_clr = 0;

    // R9: DMA release request and its override
    @(negedge clk); dma_off = 1; opt_ign = 0;
    @(negedge clk);
    check("R9 oe dma off", {7'd0, oe}, 8'h00);
    opt_ign = 1;
    @(negedge clk);
    check("R9 oe dma ignored", {7'd0, oe}, 8'h01);
    dma_off = 0; opt_ign = 0;

    // R7: power-on clear wipes held byte and output
    port_write(8'hC7, 1, 1, 1);
    latch(0, 0);
    check("R7 before clear", ext, 8'hC7);
    @(negedge clk); rst = 1;
    @(negedge clk);
    check("R7 clear addr", ext, 8'h00);
    rst = 0;
    latch(0, 0);
    check("R7 held byte cleared", ext, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule